// File: doc/BRIEF.md
# Baseline 12-bit Instruction Executor

This block is a small single-issue core that executes a fixed 12-bit accumulator-plus-file instruction set. Each accepted instruction word is decoded and executed in the cycle it arrives. The core keeps three kinds of state: an 8-bit working register W, a 32-entry by 8-bit register file, and three status flags (zero Z, digit carry DC, carry C). Byte operations carry a destination bit that sends the result either to W or back to the addressed file register. Bit operations clear, set or test one bit of a file register. Literal operations combine an 8-bit constant with W. Control operations jump, call and return through a two-level hardware stack.

The instruction stream is a fetch port. The core presents `fetch_addr_o`, and the program store answers on `fetch_word_i` with `fetch_valid_i`. The core never pushes back: every cycle in which `fetch_valid_i` is high, it takes the word as the instruction at `fetch_addr_o`. The address changes only after a word has been taken. While `fetch_valid_i` is low, no architectural state changes, so a slow store can stall the core for any number of cycles.

Skipping instructions (bit test, decrement-and-skip, increment-and-skip) do not alter the PC themselves. Instead they mark the next accepted word for squashing. That word uses one slot and has no effect, so a taken skip costs two cycles.

Top module: `exec12_core`

## Requirements
- R1: After reset the fetch address is 0, W is 0x00, all three flags are 0, and every file register reads 0x00.
- R2: In a cycle with `fetch_valid_i` low, the fetch address, W, the flags, the file registers, the stack and a pending squash are all left unchanged.
- R3: Byte operations are encoded as bits[11:6] opcode, bit[5] destination d, and bits[4:0] file address. With d=0 the result goes to W and the file register is untouched. With d=1 the result goes to the file register and W is untouched.
- R4: ADDWF (opcode 000111) computes W+f. SUBWF (opcode 000010) computes f−W. Both set Z when the result is zero. Both set C from the carry out of bit 7, which for SUBWF means no borrow. Both set DC from the carry out of bit 3. `flags_o` is {Z, DC, C}.
- R5: The following operations set Z from their result and leave C and DC unchanged: ANDWF 000101, IORWF 000100, XORWF 000110, COMF 001001, MOVF 001000, DECF 000011, INCF 001010, CLRF (0x060|f), and CLRW. SWAPF 001110 exchanges the nibbles of f and leaves all flags unchanged. MOVWF (0x020|f) stores W and leaves all flags unchanged.
- R6: RLF 001101 rotates f left through C, and RRF 001100 rotates f right through C. The bit shifted out becomes the new C. Z and DC are unchanged.
- R7: Bit clear (bits[11:8]=4) and bit set (bits[11:8]=5) change only the bit of f selected by bits[7:5]. No flag changes.
- R8: A skip squashes the next accepted word, which then advances the PC by one and has no other effect. The skipping instructions are: bit test skip-if-clear (bits[11:8]=6), bit test skip-if-set (bits[11:8]=7), DECFSZ 001011 and INCFSZ 001111 when their result is zero. The skip forms leave the flags unchanged.
- R9: Literal operations on bits[11:8] are: C moves the literal to W with no flag change; D ORs it into W; E ANDs it into W; F XORs it into W. D, E and F set Z from the result.
- R10: GOTO (bits[11:9]=101) loads the 9-bit field bits[8:0] into the PC.
- R11: CALL (bits[11:8]=9) pushes PC+1 and loads bits[7:0] into the PC with bit 8 cleared. RETLW (bits[11:8]=8) puts its literal in W and loads the PC from the stack top.
- R12: The stack has two levels. A push moves the top entry to the lower level and discards the older one. A pop copies the lower level into the top and keeps the lower level, so three nested calls followed by three returns land twice on the second return address.
- R13: Don't-care encodings are accepted. Any word 0x040–0x05F clears W and sets Z. Words 0x000–0x01F do nothing except advance the PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr_o | output | 9 | Address of the instruction wanted next |
| fetch_word_i | input | 12 | Instruction word for `fetch_addr_o` |
| fetch_valid_i | input | 1 | Word is present; it is taken on this clock edge |
| wreg_o | output | 8 | Working register W |
| flags_o | output | 3 | Status flags {Z, DC, C} |

## Verification
The hazardous overlap is a pending squash meeting either a control-transfer word or a fetch stall in the same slot. To provoke the first case, a bit test that skips is placed directly in front of a CALL. The run then checks that the squashed CALL neither redirects the PC nor pushes, because a later RETLW returns to the address pushed by a genuine CALL. To provoke the second case, `fetch_valid_i` is dropped for several cycles right after a taken skip. The run then checks that the squash is still pending when the next word is accepted: that word leaves W unchanged and only advances the PC, and the word after it executes normally.

// File: rtl/exec12_pkg.sv
`timescale 1ns/1ps
package exec12_pkg;

  localparam int INSTR_W = 12;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_DEC, OP_INC,
    OP_PASS, OP_PASSW, OP_ZERO, OP_RL, OP_RR, OP_SWAP, OP_BCLR, OP_BSET
  } alu_op_e;

  typedef enum logic [1:0] {FLOW_SEQ, FLOW_JUMP, FLOW_CALL, FLOW_RET} flow_e;

  typedef enum logic [1:0] {SK_NONE, SK_ZERO, SK_BITCLR, SK_BITSET} skip_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_lit;
    logic    wr_w;
    logic    wr_f;
    logic    upd_z;
    logic    upd_cdc;
    logic    upd_c;
    skip_e   skip;
    flow_e   flow;
  } ctrl_t;

endpackage

// File: rtl/exec12_decode.sv
`timescale 1ns/1ps
module exec12_decode
  import exec12_pkg::*;
(
  input  logic [6:0] opc,   // instruction bits [11:5]
  output ctrl_t      ctrl
);

  logic dsel;
  assign dsel = opc[0];

  always_comb begin
    ctrl      = '0;
    ctrl.op   = OP_PASS;
    ctrl.skip = SK_NONE;
    ctrl.flow = FLOW_SEQ;
    unique case (opc[6:3])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        // byte-oriented group: destination bit routes the result
        ctrl.wr_w = ~dsel;
        ctrl.wr_f = dsel;
        unique case (opc[6:1])
          6'b000000: begin
            ctrl.op   = OP_PASSW;        // MOVWF when d=1, NOP space when d=0
            ctrl.wr_w = 1'b0;
          end
          6'b000001: begin ctrl.op = OP_ZERO; ctrl.upd_z = 1'b1; end
          6'b000010: begin ctrl.op = OP_SUB;  ctrl.upd_z = 1'b1; ctrl.upd_cdc = 1'b1; end
          6'b000011: begin ctrl.op = OP_DEC;  ctrl.upd_z = 1'b1; end
          6'b000100: begin ctrl.op = OP_IOR;  ctrl.upd_z = 1'b1; end
          6'b000101: begin ctrl.op = OP_AND;  ctrl.upd_z = 1'b1; end
          6'b000110: begin ctrl.op = OP_XOR;  ctrl.upd_z = 1'b1; end
          6'b000111: begin ctrl.op = OP_ADD;  ctrl.upd_z = 1'b1; ctrl.upd_cdc = 1'b1; end
          6'b001000: begin ctrl.op = OP_PASS; ctrl.upd_z = 1'b1; end
          6'b001001: begin ctrl.op = OP_COM;  ctrl.upd_z = 1'b1; end
          6'b001010: begin ctrl.op = OP_INC;  ctrl.upd_z = 1'b1; end
          6'b001011: begin ctrl.op = OP_DEC;  ctrl.skip  = SK_ZERO; end
          6'b001100: begin ctrl.op = OP_RR;   ctrl.upd_c = 1'b1; end
          6'b001101: begin ctrl.op = OP_RL;   ctrl.upd_c = 1'b1; end
          6'b001110: begin ctrl.op = OP_SWAP; end
          default:   begin ctrl.op = OP_INC;  ctrl.skip  = SK_ZERO; end
        endcase
      end
      4'h4: begin ctrl.op = OP_BCLR; ctrl.wr_f = 1'b1; end
      4'h5: begin ctrl.op = OP_BSET; ctrl.wr_f = 1'b1; end
      4'h6: ctrl.skip = SK_BITCLR;
      4'h7: ctrl.skip = SK_BITSET;
      4'h8: begin ctrl.use_lit = 1'b1; ctrl.wr_w = 1'b1; ctrl.flow = FLOW_RET; end
      4'h9: ctrl.flow = FLOW_CALL;
      4'hA, 4'hB: ctrl.flow = FLOW_JUMP;
      4'hC: begin ctrl.use_lit = 1'b1; ctrl.wr_w = 1'b1; end
      4'hD: begin ctrl.op = OP_IOR; ctrl.use_lit = 1'b1; ctrl.wr_w = 1'b1; ctrl.upd_z = 1'b1; end
      4'hE: begin ctrl.op = OP_AND; ctrl.use_lit = 1'b1; ctrl.wr_w = 1'b1; ctrl.upd_z = 1'b1; end
      default: begin ctrl.op = OP_XOR; ctrl.use_lit = 1'b1; ctrl.wr_w = 1'b1; ctrl.upd_z = 1'b1; end
    endcase
  end

endmodule

// File: rtl/exec12_alu.sv
`timescale 1ns/1ps
module exec12_alu
  import exec12_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int NIB_W  = DATA_W / 2,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] wv,
  input  logic              c_in,
  input  logic [BIT_W-1:0]  bsel,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              dc_out,
  output logic              zero,
  output logic              bit_val
);

  logic [DATA_W:0] sum;
  logic [NIB_W:0]  nsum;
  logic [DATA_W-1:0] mask;

  assign mask    = DATA_W'(1) << bsel;
  assign bit_val = opa[bsel];

  always_comb begin
    res    = opa;
    c_out  = c_in;
    dc_out = 1'b0;
    sum    = '0;
    nsum   = '0;
    unique case (op)
      OP_ADD: begin
        sum    = {1'b0, opa} + {1'b0, wv};
        nsum   = {1'b0, opa[NIB_W-1:0]} + {1'b0, wv[NIB_W-1:0]};
        res    = sum[DATA_W-1:0];
        c_out  = sum[DATA_W];
        dc_out = nsum[NIB_W];
      end
      OP_SUB: begin
        sum    = {1'b0, opa} + {1'b0, ~wv} + (DATA_W+1)'(1);
        nsum   = {1'b0, opa[NIB_W-1:0]} + {1'b0, ~wv[NIB_W-1:0]} + (NIB_W+1)'(1);
        res    = sum[DATA_W-1:0];
        c_out  = sum[DATA_W];
        dc_out = nsum[NIB_W];
      end
      OP_AND:   res = opa & wv;
      OP_IOR:   res = opa | wv;
      OP_XOR:   res = opa ^ wv;
      OP_COM:   res = ~opa;
      OP_DEC:   res = opa - DATA_W'(1);
      OP_INC:   res = opa + DATA_W'(1);
      OP_PASS:  res = opa;
      OP_PASSW: res = wv;
      OP_ZERO:  res = '0;
      OP_RL: begin
        res   = {opa[DATA_W-2:0], c_in};
        c_out = opa[DATA_W-1];
      end
      OP_RR: begin
        res   = {c_in, opa[DATA_W-1:1]};
        c_out = opa[0];
      end
      OP_SWAP:  res = {opa[NIB_W-1:0], opa[DATA_W-1:NIB_W]};
      OP_BCLR:  res = opa & ~mask;
      default:  res = opa | mask;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/exec12_rf.sv
`timescale 1ns/1ps
module exec12_rf #(
  parameter  int DEPTH  = 32,
  parameter  int DATA_W = 8,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[i] <= '0;
      else if (we && (waddr == AW'(i)))
        cells[i] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/exec12_stack.sv
`timescale 1ns/1ps
module exec12_stack #(
  parameter int DEPTH = 2,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] top
);

  logic [ADDR_W-1:0] lvl [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) lvl[i] <= '0;
    end else if (push) begin
      lvl[0] <= din;
      for (int i = 1; i < DEPTH; i++) lvl[i] <= lvl[i-1];
    end else if (pop) begin
      // bottom level is copied upward and also kept
      for (int i = 0; i < DEPTH - 1; i++) lvl[i] <= lvl[i+1];
    end
  end

  assign top = lvl[0];

endmodule

// File: rtl/exec12_core.sv
`timescale 1ns/1ps
module exec12_core
  import exec12_pkg::*;
#(
  parameter  int PC_W      = 9,
  parameter  int RF_DEPTH  = 32,
  parameter  int STK_DEPTH = 2,
  localparam int DATA_W    = 8,
  localparam int RF_AW     = $clog2(RF_DEPTH),
  localparam int BIT_W     = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [PC_W-1:0]     fetch_addr_o,
  input  logic [INSTR_W-1:0]  fetch_word_i,
  input  logic                fetch_valid_i,
  output logic [DATA_W-1:0]   wreg_o,
  output logic [2:0]          flags_o
);

  logic [PC_W-1:0]   pc_q, pc_inc, pc_nxt, stk_top;
  logic [DATA_W-1:0] w_q, rf_rdata, opa, alu_res;
  logic              c_q, dc_q, z_q, squash_q;
  logic              alu_c, alu_dc, alu_z, alu_bit;
  logic              go, skip_hit;
  ctrl_t             ctrl;

  logic [DATA_W-1:0] lit;
  logic [RF_AW-1:0]  faddr;
  logic [BIT_W-1:0]  bsel;

  assign lit   = fetch_word_i[DATA_W-1:0];
  assign faddr = fetch_word_i[RF_AW-1:0];
  assign bsel  = fetch_word_i[7:5];

  assign go = fetch_valid_i && !squash_q;

  exec12_decode u_dec (
    .opc  (fetch_word_i[11:5]),
    .ctrl (ctrl)
  );

  exec12_rf #(.DEPTH(RF_DEPTH), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (faddr),
    .rdata (rf_rdata),
    .we    (go && ctrl.wr_f),
    .waddr (faddr),
    .wdata (alu_res)
  );

  assign opa = ctrl.use_lit ? lit : rf_rdata;

  exec12_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (ctrl.op),
    .opa     (opa),
    .wv      (w_q),
    .c_in    (c_q),
    .bsel    (bsel),
    .res     (alu_res),
    .c_out   (alu_c),
    .dc_out  (alu_dc),
    .zero    (alu_z),
    .bit_val (alu_bit)
  );

  exec12_stack #(.DEPTH(STK_DEPTH), .ADDR_W(PC_W)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (go && (ctrl.flow == FLOW_CALL)),
    .pop   (go && (ctrl.flow == FLOW_RET)),
    .din   (pc_inc),
    .top   (stk_top)
  );

  always_comb begin
    unique case (ctrl.skip)
      SK_ZERO:   skip_hit = alu_z;
      SK_BITCLR: skip_hit = ~alu_bit;
      SK_BITSET: skip_hit = alu_bit;
      default:   skip_hit = 1'b0;
    endcase
  end

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    unique case (ctrl.flow)
      FLOW_JUMP: pc_nxt = PC_W'(fetch_word_i[8:0]);
      FLOW_CALL: pc_nxt = PC_W'(fetch_word_i[7:0]);
      FLOW_RET:  pc_nxt = stk_top;
      default:   pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      w_q      <= '0;
      c_q      <= 1'b0;
      dc_q     <= 1'b0;
      z_q      <= 1'b0;
      squash_q <= 1'b0;
    end else if (fetch_valid_i) begin
      if (squash_q) begin
        pc_q     <= pc_inc;
        squash_q <= 1'b0;
      end else begin
        pc_q     <= pc_nxt;
        squash_q <= skip_hit;
        if (ctrl.wr_w)    w_q  <= alu_res;
        if (ctrl.upd_z)   z_q  <= alu_z;
        if (ctrl.upd_cdc) begin
          c_q  <= alu_c;
          dc_q <= alu_dc;
        end
        if (ctrl.upd_c)   c_q  <= alu_c;
      end
    end
  end

  assign fetch_addr_o = pc_q;
  assign wreg_o       = w_q;
  assign flags_o      = {z_q, dc_q, c_q};

endmodule

// File: rtl/exec12_core_chk.sv
`timescale 1ns/1ps
module exec12_core_chk #(
  parameter int PC_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_addr_o,
  input logic [11:0]     fetch_word_i,
  input logic            fetch_valid_i,
  input logic [7:0]      wreg_o,
  input logic [2:0]      flags_o,
  input logic            squash_q
);

  logic exec_now;
  assign exec_now = fetch_valid_i && !squash_q;

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid_i |=> $stable(fetch_addr_o) && $stable(wreg_o) && $stable(flags_o));

  a_r8_squash_inert: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_i && squash_q |=>
      (fetch_addr_o == PC_W'($past(fetch_addr_o) + 1)) && $stable(wreg_o) && $stable(flags_o));

  a_r9_movlw_loads: assert property (@(posedge clk) disable iff (!rst_n)
    exec_now && (fetch_word_i[11:8] == 4'hC) |=>
      (wreg_o == $past(fetch_word_i[7:0])) && $stable(flags_o));

  a_r10_goto_target: assert property (@(posedge clk) disable iff (!rst_n)
    exec_now && (fetch_word_i[11:9] == 3'b101) |=>
      fetch_addr_o == PC_W'($past(fetch_word_i[8:0])));

  a_r11_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    exec_now && (fetch_word_i[11:8] == 4'h9) |=>
      fetch_addr_o == PC_W'($past(fetch_word_i[7:0])));

endmodule

bind exec12_core exec12_core_chk #(.PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_addr_o  (fetch_addr_o),
  .fetch_word_i  (fetch_word_i),
  .fetch_valid_i (fetch_valid_i),
  .wreg_o        (wreg_o),
  .flags_o       (flags_o),
  .squash_q      (squash_q)
);

// File: tb/exec12_core_test.sv
`timescale 1ns/1ps
module exec12_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [8:0]  addr;
  logic [11:0] word;
  logic [7:0]  wreg;
  logic [2:0]  flags;
  logic [11:0] prog [512];
  int          n_vec = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  assign word = prog[addr];

  exec12_core uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_addr_o  (addr),
    .fetch_word_i  (word),
    .fetch_valid_i (valid),
    .wreg_o        (wreg),
    .flags_o       (flags)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 512; i++) prog[i] = 12'h000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    valid = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = 12'h205;                       // MOVF 5,0
    do_reset();
    chk("R1 pc after reset", 12'(addr), 12'h000);
    chk("R1 W after reset", 12'(wreg), 12'h000);
    chk("R1 flags after reset", 12'(flags), 12'h000);
    run(1);
    chk("R1 file reg zero", 12'(wreg), 12'h000);
    chk("R1 Z from zero file", 12'(flags), 12'h004);
  endtask

  task automatic t_add();
    clear_prog();
    prog[0] = 12'hC3A; prog[1] = 12'h021; prog[2] = 12'hCC8;
    prog[3] = 12'h1C1;                       // ADDWF 1,0
    prog[4] = 12'h201;                       // MOVF 1,0
    prog[5] = 12'h1E1;                       // ADDWF 1,1
    prog[6] = 12'h201;
    do_reset();
    run(4);
    chk("R4 add sum", 12'(wreg), 12'h002);
    chk("R4 add C DC", 12'(flags), 12'h003);
    run(1);
    chk("R3 d=0 leaves f", 12'(wreg), 12'h03A);
    run(1);
    chk("R3 d=1 leaves W", 12'(wreg), 12'h03A);
    chk("R4 add DC only", 12'(flags), 12'h002);
    run(1);
    chk("R3 d=1 writes f", 12'(wreg), 12'h074);
  endtask

  task automatic t_sub();
    clear_prog();
    prog[0] = 12'hC05; prog[1] = 12'h022; prog[2] = 12'hC05;
    prog[3] = 12'h082;                       // SUBWF 2,0
    prog[4] = 12'hC06; prog[5] = 12'h082;
    prog[6] = 12'hC10; prog[7] = 12'h023; prog[8] = 12'hC01;
    prog[9] = 12'h0A3;                       // SUBWF 3,1
    prog[10] = 12'h203;
    do_reset();
    run(4);
    chk("R4 sub equal result", 12'(wreg), 12'h000);
    chk("R4 sub equal flags", 12'(flags), 12'h007);
    run(2);
    chk("R4 sub borrow result", 12'(wreg), 12'h0FF);
    chk("R4 sub borrow flags", 12'(flags), 12'h000);
    run(4);
    chk("R4 sub nibble borrow keeps W", 12'(wreg), 12'h001);
    chk("R4 sub nibble borrow flags", 12'(flags), 12'h001);
    run(1);
    chk("R4 sub into f", 12'(wreg), 12'h00F);
  endtask

  task automatic t_logic();
    clear_prog();
    prog[0] = 12'hCC5; prog[1] = 12'h024; prog[2] = 12'hC3C;
    prog[3] = 12'h144;                       // ANDWF 4,0
    prog[4] = 12'h104;                       // IORWF 4,0
    prog[5] = 12'h184;                       // XORWF 4,0
    prog[6] = 12'h384;                       // SWAPF 4,0
    prog[7] = 12'h244;                       // COMF 4,0
    prog[8] = 12'h064;                       // CLRF 4
    prog[9] = 12'hC77;                       // MOVLW 77
    prog[10] = 12'hD00;                      // IORLW 00
    prog[11] = 12'h05F;                      // CLRW, don't-care bits set
    prog[12] = 12'hC12;
    prog[13] = 12'h204;                      // MOVF 4,0
    do_reset();
    run(4);
    chk("R5 and", 12'(wreg), 12'h004);
    run(1);
    chk("R5 ior", 12'(wreg), 12'h0C5);
    run(1);
    chk("R5 xor", 12'(wreg), 12'h000);
    chk("R5 xor Z", 12'(flags), 12'h004);
    run(1);
    chk("R5 swap", 12'(wreg), 12'h05C);
    chk("R5 swap keeps Z", 12'(flags), 12'h004);
    run(1);
    chk("R5 com", 12'(wreg), 12'h03A);
    chk("R5 com clears Z", 12'(flags), 12'h000);
    run(2);
    chk("R9 movlw value", 12'(wreg), 12'h077);
    chk("R9 movlw keeps Z from clrf", 12'(flags), 12'h004);
    run(1);
    chk("R9 iorlw Z", 12'(flags), 12'h000);
    run(1);
    chk("R13 clrw dont-care", 12'(wreg), 12'h000);
    chk("R13 clrw Z", 12'(flags), 12'h004);
    run(2);
    chk("R5 clrf cleared f", 12'(wreg), 12'h000);
  endtask

  task automatic t_literal();
    clear_prog();
    prog[0] = 12'hC5A; prog[1] = 12'hE3C;    // ANDLW
    prog[2] = 12'hD81;                       // IORLW
    prog[3] = 12'hF99;                       // XORLW
    do_reset();
    run(2);
    chk("R9 andlw", 12'(wreg), 12'h018);
    run(1);
    chk("R9 iorlw", 12'(wreg), 12'h099);
    run(1);
    chk("R9 xorlw", 12'(wreg), 12'h000);
    chk("R9 xorlw Z", 12'(flags), 12'h004);
  endtask

  task automatic t_rotate();
    clear_prog();
    prog[0] = 12'hC81; prog[1] = 12'h025;
    prog[2] = 12'h365;                       // RLF 5,1
    prog[3] = 12'h345;                       // RLF 5,0
    prog[4] = 12'h325;                       // RRF 5,1
    prog[5] = 12'h305;                       // RRF 5,0
    prog[6] = 12'h305;
    do_reset();
    run(4);
    chk("R6 rlf through C", 12'(wreg), 12'h005);
    chk("R6 rlf C out", 12'(flags), 12'h000);
    run(2);
    chk("R6 rrf result", 12'(wreg), 12'h000);
    chk("R6 rrf C set Z kept", 12'(flags), 12'h001);
    run(1);
    chk("R6 rrf C in", 12'(wreg), 12'h080);
  endtask

  task automatic t_skip();
    clear_prog();
    prog[0] = 12'h066; prog[1] = 12'h566; prog[2] = 12'h5E6;
    prog[3] = 12'h466; prog[4] = 12'h206;
    prog[5] = 12'h7E6; prog[6] = 12'hC11; prog[7] = 12'hC22;
    prog[8] = 12'h6E6; prog[9] = 12'hC33;
    prog[10] = 12'h606; prog[11] = 12'hC44; prog[12] = 12'hC55;
    prog[13] = 12'hC02; prog[14] = 12'h027; prog[15] = 12'h2E7;
    prog[16] = 12'hC66; prog[17] = 12'h2E7; prog[18] = 12'hC77;
    prog[19] = 12'h207;
    prog[20] = 12'hCFF; prog[21] = 12'h028; prog[22] = 12'h3C8;
    prog[23] = 12'hC99; prog[24] = 12'h000; prog[25] = 12'h208;
    do_reset();
    run(5);
    chk("R7 set and clear bits", 12'(wreg), 12'h080);
    run(2);
    chk("R8 btfss skips pc", 12'(addr), 12'h007);
    chk("R8 squashed movlw inert", 12'(wreg), 12'h080);
    run(1);
    chk("R8 after skip", 12'(wreg), 12'h022);
    run(2);
    chk("R8 btfsc no skip", 12'(wreg), 12'h033);
    run(3);
    chk("R8 btfsc skip", 12'(wreg), 12'h055);
    run(5);
    chk("R8 decfsz nonzero no skip", 12'(wreg), 12'h066);
    run(2);
    chk("R8 decfsz zero skip", 12'(wreg), 12'h000);
    chk("R8 decfsz pc", 12'(addr), 12'h014);
    run(5);
    chk("R8 incfsz to W skip", 12'(wreg), 12'h000);
    chk("R8 incfsz pc", 12'(addr), 12'h019);
    run(1);
    chk("R3 incfsz d=0 leaves f", 12'(wreg), 12'h0FF);
  endtask

  task automatic t_stall();
    clear_prog();
    prog[0] = 12'h649; prog[1] = 12'hCAA; prog[2] = 12'hCBB;
    do_reset();
    run(1);
    idle(5);
    chk("R2 stall holds pc", 12'(addr), 12'h001);
    chk("R2 stall holds W", 12'(wreg), 12'h000);
    run(1);
    chk("R2 squash survives stall pc", 12'(addr), 12'h002);
    chk("R2 squash survives stall W", 12'(wreg), 12'h000);
    run(1);
    chk("R2 resume", 12'(wreg), 12'h0BB);
  endtask

  task automatic t_flow();
    clear_prog();
    prog[0] = 12'hBF0;                       // GOTO 1F0
    prog[9'h1F0] = 12'h940;                  // CALL 40
    prog[9'h040] = 12'h950;                  // CALL 50
    prog[9'h050] = 12'h85A;                  // RETLW 5A
    prog[9'h041] = 12'h86B;                  // RETLW 6B
    prog[9'h1F1] = 12'hA03;                  // GOTO 003
    prog[3] = 12'h960; prog[9'h060] = 12'h970; prog[9'h070] = 12'h980;
    prog[9'h080] = 12'h801; prog[9'h071] = 12'h802; prog[9'h061] = 12'h803;
    do_reset();
    run(1);
    chk("R10 goto 9-bit", 12'(addr), 12'h1F0);
    run(1);
    chk("R11 call clears bit 8", 12'(addr), 12'h040);
    run(1);
    chk("R11 nested call", 12'(addr), 12'h050);
    run(1);
    chk("R11 retlw pc", 12'(addr), 12'h041);
    chk("R11 retlw W", 12'(wreg), 12'h05A);
    run(1);
    chk("R11 return to pc+1", 12'(addr), 12'h1F1);
    chk("R11 second retlw W", 12'(wreg), 12'h06B);
    run(1);
    chk("R10 goto low", 12'(addr), 12'h003);
    run(4);
    chk("R12 first return", 12'(addr), 12'h071);
    run(1);
    chk("R12 second return", 12'(addr), 12'h061);
    run(1);
    chk("R12 overflowed return", 12'(addr), 12'h061);
    chk("R12 third retlw W", 12'(wreg), 12'h003);
  endtask

  task automatic t_skip_call();
    clear_prog();
    prog[0] = 12'h60A; prog[1] = 12'h930; prog[2] = 12'h920;
    prog[9'h020] = 12'h821;
    do_reset();
    run(2);
    chk("R8 squashed call no jump", 12'(addr), 12'h002);
    run(1);
    chk("R11 call after squash", 12'(addr), 12'h020);
    run(1);
    chk("R8 squashed call no push", 12'(addr), 12'h003);
    chk("R11 retlw W", 12'(wreg), 12'h021);
  endtask

  task automatic t_nop_space();
    clear_prog();
    prog[0] = 12'hC3C; prog[1] = 12'h003; prog[2] = 12'h01F;
    do_reset();
    run(3);
    chk("R13 nop space W", 12'(wreg), 12'h03C);
    chk("R13 nop space pc", 12'(addr), 12'h003);
    chk("R13 nop space flags", 12'(flags), 12'h000);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_literal();
    t_rotate();
    t_skip();
    t_stall();
    t_flow();
    t_skip_call();
    t_nop_space();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule